// File: doc/BRIEF.md
# Hall Sensor Direction and Speed Estimator

The block sits in a brushless motor controller and runs once per control tick, qualified by a one-cycle tick enable. On every tick it samples the three Hall sensor bits, notices whether any of them changed since the previous tick, and on a change converts the new Hall code into one of six sectors. The signed step from the old sector to the new one decides whether the rotor is turning forward or in reverse.

Between transitions a saturating tick counter measures the time spent in the current sector. At each transition that count is latched as the sector period, and the change from the previous period is kept as a measure of jitter. A signed raw speed (a configurable coefficient divided by the latched period, signed by direction) is forced to zero when the counter stalls or when the direction has just reversed. It is then smoothed by a first-order filter with a percentage weight. Two hysteresis flags, one on the filtered speed magnitude and one on the period jitter, are produced for later commutation decisions. Both divisions share one iterative divider, so each result arrives a fixed number of cycles after its tick and is marked by a one-cycle valid strobe.

Top module: `hall_speed_est`

## Requirements
- R1: The Hall code is {hallA, hallB, hallC} (hallA is bit 2). Codes 5, 4, 6, 2, 3, 1 map to sectors 0, 1, 2, 3, 4, 5 in that order; codes 0 and 7 map to an internal sector value 6, which takes part in the direction arithmetic but appears clipped to 5 on the `sector` output.
- R2: A transition is taken only on a tick whose Hall code differs from the code sampled on the previous tick; Hall activity between ticks and ticks with an unchanged code start no transition.
- R3: On a transition the new sector minus the previous sector (as signed integers) of +1 or -5 sets `dirFwd` to 1 (forward); any other difference sets it to 0 (reverse). Between transitions `dirFwd` holds.
- R4: On every tick `runCnt` becomes 1 if a transition occurred, otherwise min(runCnt, cfgMaxCnt) + 1.
- R5: On a transition `periodCnt` takes the value `runCnt` held before the tick, and the signed difference between that value and the former `periodCnt` is kept as the period jitter.
- R6: The raw speed of a tick is 0 when there was no transition and the pre-tick `runCnt` was at least cfgMaxCnt, or when the current direction differs from the direction before the last transition; otherwise it is cfgSpeedCoef / periodCnt (truncated), negated for reverse.
- R7: `speedFilt` becomes ((100 - cfgFiltPct) * previous speedFilt + cfgFiltPct * raw) / 100 with the division truncated toward zero.
- R8: `spdFlag` sets when |speedFilt| >= cfgSpdHi, otherwise clears when |speedFilt| <= cfgSpdLo, otherwise holds.
- R9: `jitFlag` sets when |jitter| >= cfgJitHi, otherwise clears when |jitter| <= cfgJitLo, otherwise holds.
- R10: After reset `runCnt` and `periodCnt` equal cfgMaxCnt, the former period equals cfgMaxCnt, the jitter and `speedFilt` are 0, both flags are 0, `dirFwd` is 1 and `sector` is 0.
- R11: `speedValid` pulses for one cycle a fixed number of cycles after each tick; `speedFilt`, `spdFlag` and `jitFlag` change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle control tick |
| hallA | input | 1 | Hall sensor A (code bit 2) |
| hallB | input | 1 | Hall sensor B (code bit 1) |
| hallC | input | 1 | Hall sensor C (code bit 0) |
| cfgMaxCnt | input | CNT_W | Stall limit of the tick counter |
| cfgSpeedCoef | input | COEF_W | Speed coefficient (dividend) |
| cfgFiltPct | input | PCT_W | Filter weight of the new sample, 0 to 100 |
| cfgSpdHi | input | COEF_W+1 | Speed flag set threshold |
| cfgSpdLo | input | COEF_W+1 | Speed flag clear threshold |
| cfgJitHi | input | CNT_W | Jitter flag set threshold |
| cfgJitLo | input | CNT_W | Jitter flag clear threshold |
| sector | output | 3 | Current sector, 0 to 5 |
| dirFwd | output | 1 | 1 forward, 0 reverse |
| periodCnt | output | CNT_W | Latched sector period in ticks |
| runCnt | output | CNT_W | Running tick counter |
| speedFilt | output | COEF_W+2 | Filtered signed speed |
| speedValid | output | 1 | Filtered speed updated strobe |
| spdFlag | output | 1 | Speed hysteresis flag |
| jitFlag | output | 1 | Period jitter hysteresis flag |

## Verification
The assertions take for granted that ticks are spaced further apart than the two divider passes (about 60 cycles at the default widths), that tickEn is low during reset, that the configuration stays constant, that cfgMaxCnt lies between 1 and two less than the counter range, and that cfgFiltPct does not exceed 100. The stimulus holds the configuration fixed except for the filter weight, which it changes only between ticks, and it waits for each valid strobe plus a few idle cycles before issuing the next tick. Within that envelope it walks every ordered pair of Hall codes, runs both rotation directions with varied dwell times, stalls past the limit, and toggles the Hall inputs between ticks.

// File: rtl/hallest_pkg.sv
package hallest_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // sample Hall inputs, update counter and direction
    logic startRate;  // start coefficient / period division
    logic startFilt;  // start filter numerator / 100 division
    logic commit;     // write filtered speed and flags
  } stepCtl_t;

  localparam logic [2:0] SECTOR_BAD  = 3'd6;
  localparam logic [2:0] SECTOR_LAST = 3'd5;
  localparam int         PCT_FULL    = 100;

  function automatic logic [2:0] hallToSector(input logic [2:0] code);
    logic [2:0] sec;
    case (code)
      3'b101:  sec = 3'd0;
      3'b100:  sec = 3'd1;
      3'b110:  sec = 3'd2;
      3'b010:  sec = 3'd3;
      3'b011:  sec = 3'd4;
      3'b001:  sec = 3'd5;
      default: sec = SECTOR_BAD;
    endcase
    return sec;
  endfunction

endpackage

// File: rtl/hall_divu.sv
module hall_divu #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  dsr;
  logic [CW-1:0] left;
  logic          busy;
  logic [W:0]    trial;

  assign trial = {rem, quotient[W-1]} - {1'b0, dsr};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem      <= '0;
      dsr      <= '0;
      quotient <= '0;
      left     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem      <= '0;
        quotient <= dividend;
        dsr      <= divisor;
        left     <= CW'(W);
        busy     <= 1'b1;
      end else if (busy) begin
        if (!trial[W]) begin
          rem      <= trial[W-1:0];
          quotient <= {quotient[W-2:0], 1'b1};
        end else begin
          rem      <= {rem[W-2:0], quotient[W-1]};
          quotient <= {quotient[W-2:0], 1'b0};
        end
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hall_est_ctrl.sv
module hall_est_ctrl
  import hallest_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tickEn,
  input  logic     divDone,
  output stepCtl_t ctl
);
  typedef enum logic [1:0] {
    ST_IDLE, ST_RATE_GO, ST_RATE_WAIT, ST_FILT_WAIT
  } seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (tickEn) begin
          ctl.capture = 1'b1;
          stateNext   = ST_RATE_GO;
        end
      end
      ST_RATE_GO: begin
        ctl.startRate = 1'b1;
        stateNext     = ST_RATE_WAIT;
      end
      ST_RATE_WAIT: begin
        if (divDone) begin
          ctl.startFilt = 1'b1;
          stateNext     = ST_FILT_WAIT;
        end
      end
      ST_FILT_WAIT: begin
        if (divDone) begin
          ctl.commit = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end
endmodule

// File: rtl/hall_est_dp.sv
module hall_est_dp
  import hallest_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int COEF_W = 16,
  parameter int PCT_W  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  stepCtl_t            ctl,
  input  logic [2:0]          hallCode,
  input  logic [CNT_W-1:0]    cfgMaxCnt,
  input  logic [COEF_W-1:0]   cfgSpeedCoef,
  input  logic [PCT_W-1:0]    cfgFiltPct,
  input  logic [COEF_W:0]     cfgSpdHi,
  input  logic [COEF_W:0]     cfgSpdLo,
  input  logic [CNT_W-1:0]    cfgJitHi,
  input  logic [CNT_W-1:0]    cfgJitLo,
  output logic                divDone,
  output logic [2:0]          sector,
  output logic                dirFwd,
  output logic [CNT_W-1:0]    periodCnt,
  output logic [CNT_W-1:0]    runCnt,
  output logic [COEF_W+1:0]   speedFilt,
  output logic                speedValid,
  output logic                spdFlag,
  output logic                jitFlag
);
  localparam int SW = COEF_W + 2;          // signed speed width
  localparam int NW = SW + PCT_W + 2;      // filter numerator / divider width
  localparam int JW = CNT_W + 1;           // signed jitter width

  // tick state
  logic [2:0]           prevCode;
  logic [2:0]           prevSec;
  logic                 dirPrevFwd;
  logic [CNT_W-1:0]     periodOld;
  logic signed [JW-1:0] jitter;
  logic                 zeroSpeed;
  logic                 numNegQ;

  // capture-cycle terms
  logic                 hallEdge;
  logic [CNT_W-1:0]     cntClip, cntNext;
  logic [2:0]           secNew;
  logic signed [3:0]    secStep;
  logic                 fwdNew, fwdEff, fwdPrevEff, stallNow;

  always_comb begin
    hallEdge   = (hallCode != prevCode);
    cntClip    = (runCnt < cfgMaxCnt) ? runCnt : cfgMaxCnt;
    cntNext    = hallEdge ? CNT_W'(1) : cntClip + 1'b1;
    secNew     = hallToSector(hallCode);
    secStep    = $signed({1'b0, secNew}) - $signed({1'b0, prevSec});
    fwdNew     = (secStep == 4'sd1) || (secStep == -4'sd5);
    fwdEff     = hallEdge ? fwdNew : dirFwd;
    fwdPrevEff = hallEdge ? dirFwd : dirPrevFwd;
    stallNow   = !hallEdge && (runCnt >= cfgMaxCnt);
  end

  // shared divider
  logic [NW-1:0] divA, divB, divQ;
  logic          divStart;

  logic signed [NW-1:0] rawExt, filtExt, keepW, takeW, filtNum;
  logic [NW-1:0]        numAbs;
  logic                 numNeg;
  logic [COEF_W-1:0]    rateQ;

  always_comb begin
    rateQ   = divQ[COEF_W-1:0];
    if (zeroSpeed)   rawExt = '0;
    else if (dirFwd) rawExt = $signed({{(NW-COEF_W){1'b0}}, rateQ});
    else             rawExt = -$signed({{(NW-COEF_W){1'b0}}, rateQ});
    filtExt = NW'(speedFilt) ;
    filtExt = {{(NW-SW){speedFilt[SW-1]}}, speedFilt};
    takeW   = $signed({{(NW-PCT_W){1'b0}}, cfgFiltPct});
    keepW   = $signed(NW'(PCT_FULL)) - takeW;
    filtNum = keepW * filtExt + takeW * rawExt;
    numNeg  = filtNum[NW-1];
    numAbs  = numNeg ? NW'(-filtNum) : NW'(filtNum);
  end

  assign divStart = ctl.startRate | ctl.startFilt;
  assign divA     = ctl.startFilt ? numAbs : {{(NW-COEF_W){1'b0}}, cfgSpeedCoef};
  assign divB     = ctl.startFilt ? NW'(PCT_FULL) : {{(NW-CNT_W){1'b0}}, periodCnt};

  hall_divu #(.W(NW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (divStart),
    .dividend (divA),
    .divisor  (divB),
    .quotient (divQ),
    .done     (divDone)
  );

  // commit-cycle terms
  logic signed [SW-1:0] filtNew;
  logic [SW-1:0]        spdAbs;
  logic [JW-1:0]        jitAbs;

  always_comb begin
    filtNew = numNegQ ? -$signed(divQ[SW-1:0]) : $signed(divQ[SW-1:0]);
    spdAbs  = filtNew[SW-1] ? SW'(-filtNew) : SW'(filtNew);
    jitAbs  = jitter[JW-1] ? JW'(-jitter) : JW'(jitter);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCode   <= 3'd0;
      prevSec    <= 3'd0;
      dirFwd     <= 1'b1;
      dirPrevFwd <= 1'b1;
      runCnt     <= cfgMaxCnt;
      periodCnt  <= cfgMaxCnt;
      periodOld  <= cfgMaxCnt;
      jitter     <= '0;
      zeroSpeed  <= 1'b0;
      numNegQ    <= 1'b0;
      speedFilt  <= '0;
      speedValid <= 1'b0;
      spdFlag    <= 1'b0;
      jitFlag    <= 1'b0;
    end else begin
      speedValid <= ctl.commit;
      if (ctl.capture) begin
        prevCode  <= hallCode;
        runCnt    <= cntNext;
        zeroSpeed <= stallNow || (fwdEff != fwdPrevEff);
        if (hallEdge) begin
          prevSec    <= secNew;
          dirFwd     <= fwdNew;
          dirPrevFwd <= dirFwd;
          periodCnt  <= runCnt;
          periodOld  <= periodCnt;
          jitter     <= $signed({1'b0, runCnt}) - $signed({1'b0, periodCnt});
        end
      end
      if (ctl.startFilt) numNegQ <= numNeg;
      if (ctl.commit) begin
        speedFilt <= filtNew;
        if (spdAbs >= {1'b0, cfgSpdHi})      spdFlag <= 1'b1;
        else if (spdAbs <= {1'b0, cfgSpdLo}) spdFlag <= 1'b0;
        if (jitAbs >= {1'b0, cfgJitHi})      jitFlag <= 1'b1;
        else if (jitAbs <= {1'b0, cfgJitLo}) jitFlag <= 1'b0;
      end
    end
  end

  assign sector = (prevSec > SECTOR_LAST) ? SECTOR_LAST : prevSec;

endmodule

// File: rtl/hall_speed_est.sv
module hall_speed_est
  import hallest_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int COEF_W = 16,
  parameter int PCT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              hallA,
  input  logic              hallB,
  input  logic              hallC,
  input  logic [CNT_W-1:0]  cfgMaxCnt,
  input  logic [COEF_W-1:0] cfgSpeedCoef,
  input  logic [PCT_W-1:0]  cfgFiltPct,
  input  logic [COEF_W:0]   cfgSpdHi,
  input  logic [COEF_W:0]   cfgSpdLo,
  input  logic [CNT_W-1:0]  cfgJitHi,
  input  logic [CNT_W-1:0]  cfgJitLo,
  output logic [2:0]        sector,
  output logic              dirFwd,
  output logic [CNT_W-1:0]  periodCnt,
  output logic [CNT_W-1:0]  runCnt,
  output logic [COEF_W+1:0] speedFilt,
  output logic              speedValid,
  output logic              spdFlag,
  output logic              jitFlag
);
  stepCtl_t ctl;
  logic     divDone;

  hall_est_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tickEn  (tickEn),
    .divDone (divDone),
    .ctl     (ctl)
  );

  hall_est_dp #(.CNT_W(CNT_W), .COEF_W(COEF_W), .PCT_W(PCT_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .hallCode     ({hallA, hallB, hallC}),
    .cfgMaxCnt    (cfgMaxCnt),
    .cfgSpeedCoef (cfgSpeedCoef),
    .cfgFiltPct   (cfgFiltPct),
    .cfgSpdHi     (cfgSpdHi),
    .cfgSpdLo     (cfgSpdLo),
    .cfgJitHi     (cfgJitHi),
    .cfgJitLo     (cfgJitLo),
    .divDone      (divDone),
    .sector       (sector),
    .dirFwd       (dirFwd),
    .periodCnt    (periodCnt),
    .runCnt       (runCnt),
    .speedFilt    (speedFilt),
    .speedValid   (speedValid),
    .spdFlag      (spdFlag),
    .jitFlag      (jitFlag)
  );
endmodule

// File: rtl/hall_speed_est_chk.sv
module hall_speed_est_chk #(
  parameter int CNT_W  = 12,
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic              hallA,
  input logic              hallB,
  input logic              hallC,
  input logic [CNT_W-1:0]  cfgMaxCnt,
  input logic [COEF_W:0]   cfgSpdHi,
  input logic [COEF_W:0]   cfgSpdLo,
  input logic [2:0]        sector,
  input logic              dirFwd,
  input logic [CNT_W-1:0]  periodCnt,
  input logic [CNT_W-1:0]  runCnt,
  input logic [COEF_W+1:0] speedFilt,
  input logic              speedValid,
  input logic              spdFlag
);
  logic [2:0]        codeNow, lastCode;
  logic              changed;
  logic [COEF_W+1:0] spdMag;

  assign codeNow = {hallA, hallB, hallC};
  assign changed = (codeNow != lastCode);
  assign spdMag  = speedFilt[COEF_W+1] ? -speedFilt : speedFilt;

  always_ff @(posedge clk) begin
    if (rst)         lastCode <= 3'd0;
    else if (tickEn) lastCode <= codeNow;
  end

  assert_sector_range_R1: assert property (@(posedge clk) disable iff (rst)
    sector <= 3'd5);

  assert_count_restart_R4: assert property (@(posedge clk) disable iff (rst)
    tickEn && changed |=> runCnt == CNT_W'(1));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    tickEn && !changed |=>
      runCnt == ((($past(runCnt) < cfgMaxCnt) ? $past(runCnt) : cfgMaxCnt) + 1'b1));

  assert_period_latch_R5: assert property (@(posedge clk) disable iff (rst)
    tickEn && changed |=> periodCnt == $past(runCnt));

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(tickEn && changed) |=> $stable(dirFwd));

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    speedValid |=> !speedValid);

  assert_speed_update_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(speedFilt) |-> speedValid);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(spdFlag) |-> spdMag >= {1'b0, cfgSpdHi});

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(spdFlag) |-> spdMag <= {1'b0, cfgSpdLo});
endmodule

bind hall_speed_est hall_speed_est_chk #(.CNT_W(CNT_W), .COEF_W(COEF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tickEn     (tickEn),
  .hallA      (hallA),
  .hallB      (hallB),
  .hallC      (hallC),
  .cfgMaxCnt  (cfgMaxCnt),
  .cfgSpdHi   (cfgSpdHi),
  .cfgSpdLo   (cfgSpdLo),
  .sector     (sector),
  .dirFwd     (dirFwd),
  .periodCnt  (periodCnt),
  .runCnt     (runCnt),
  .speedFilt  (speedFilt),
  .speedValid (speedValid),
  .spdFlag    (spdFlag)
);

// File: tb/hall_speed_est_test.sv
module hall_speed_est_test;
  localparam int CNT_W  = 12;
  localparam int COEF_W = 16;
  localparam int PCT_W  = 7;

  localparam int MAXC = 20;
  localparam int COEF = 6000;
  localparam int SHI  = 1500;
  localparam int SLO  = 800;
  localparam int JHI  = 3;
  localparam int JLO  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic hallA = 1'b0, hallB = 1'b0, hallC = 1'b0;
  logic [PCT_W-1:0] filtPct = PCT_W'(100);

  logic [2:0]        sector;
  logic              dirFwd;
  logic [CNT_W-1:0]  periodCnt, runCnt;
  logic [COEF_W+1:0] speedFilt;
  logic              speedValid, spdFlag, jitFlag;

  always #10 clk = ~clk;

  hall_speed_est #(.CNT_W(CNT_W), .COEF_W(COEF_W), .PCT_W(PCT_W)) uut (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .hallA(hallA), .hallB(hallB), .hallC(hallC),
    .cfgMaxCnt(CNT_W'(MAXC)), .cfgSpeedCoef(COEF_W'(COEF)), .cfgFiltPct(filtPct),
    .cfgSpdHi((COEF_W+1)'(SHI)), .cfgSpdLo((COEF_W+1)'(SLO)),
    .cfgJitHi(CNT_W'(JHI)), .cfgJitLo(CNT_W'(JLO)),
    .sector(sector), .dirFwd(dirFwd), .periodCnt(periodCnt), .runCnt(runCnt),
    .speedFilt(speedFilt), .speedValid(speedValid), .spdFlag(spdFlag), .jitFlag(jitFlag)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference state
  int mPrevCode = 0, mPrevSec = 0, mFwd = 1, mPrevFwd = 1;
  int mCnt = MAXC, mPeriod = MAXC, mDelta = 0, mFilt = 0;
  int mSpdF = 0, mJitF = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int secOf(input int code);
    case (code)
      5: return 0;
      4: return 1;
      6: return 2;
      2: return 3;
      3: return 4;
      1: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic modelStep(input int code);
    int clip, raw, diff, k;
    bit edgeSeen, stall;
    edgeSeen = (code != mPrevCode);
    clip     = (mCnt < MAXC) ? mCnt : MAXC;
    stall    = !edgeSeen && (clip + 1 > MAXC);
    if (edgeSeen) begin
      diff     = secOf(code) - mPrevSec;
      mPrevFwd = mFwd;
      mFwd     = (diff == 1 || diff == -5) ? 1 : 0;
      mPrevSec = secOf(code);
      mDelta   = mCnt - mPeriod;
      mPeriod  = mCnt;
    end
    mCnt      = edgeSeen ? 1 : clip + 1;
    mPrevCode = code;
    if (stall || mFwd != mPrevFwd) raw = 0;
    else raw = mFwd ? COEF / mPeriod : -(COEF / mPeriod);
    k     = int'(filtPct);
    mFilt = ((100 - k) * mFilt + k * raw) / 100;
    if (iabs(mFilt) >= SHI) mSpdF = 1;
    else if (iabs(mFilt) <= SLO) mSpdF = 0;
    if (iabs(mDelta) >= JHI) mJitF = 1;
    else if (iabs(mDelta) <= JLO) mJitF = 0;
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R1 sector"}, int'(sector), (mPrevSec > 5) ? 5 : mPrevSec);
    check({tag, " R3 dirFwd"}, int'(dirFwd), mFwd);
    check({tag, " R4 runCnt"}, int'(runCnt), mCnt);
    check({tag, " R5 periodCnt"}, int'(periodCnt), mPeriod);
    check({tag, " R6/R7 speedFilt"}, int'($signed(speedFilt)), mFilt);
    check({tag, " R8 spdFlag"}, int'(spdFlag), mSpdF);
    check({tag, " R9 jitFlag"}, int'(jitFlag), mJitF);
  endtask

  task automatic tick(input int code, input string tag);
    bit seen;
    @(negedge clk);
    {hallA, hallB, hallC} = 3'(code);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    modelStep(code);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (speedValid) begin
        seen = 1;
        break;
      end
    end
    check({tag, " R11 speedValid strobe"}, int'(seen), 1);
    checkAll(tag);
    repeat (2) @(negedge clk);
  endtask

  // forward order of Hall codes (sectors 0..5)
  int fwdSeq[6] = '{5, 4, 6, 2, 3, 1};

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 runCnt reset", int'(runCnt), MAXC);
    check("R10 periodCnt reset", int'(periodCnt), MAXC);
    check("R10 speedFilt reset", int'($signed(speedFilt)), 0);
    check("R10 dirFwd reset", int'(dirFwd), 1);
    check("R10 sector reset", int'(sector), 0);
    check("R10 flags reset", int'({spdFlag, jitFlag}), 0);

    // forward rotation with varying dwell, unfiltered (k=100)
    for (int s = 0; s < 18; s++) begin
      for (int h = 0; h < 1 + (s % 4); h++) tick(fwdSeq[s % 6], "fwd");
    end
    // steady fast forward to set speed flag (R8)
    for (int s = 0; s < 12; s++) begin
      tick(fwdSeq[s % 6], "fast");
      tick(fwdSeq[s % 6], "fast");
      tick(fwdSeq[s % 6], "fast");
    end
    // slow down to clear speed flag
    for (int s = 0; s < 6; s++) begin
      for (int h = 0; h < 9; h++) tick(fwdSeq[s % 6], "slow");
    end
    // reversal (R3, R6)
    for (int s = 5; s >= 0; s--) begin
      tick(fwdSeq[s], "rev");
      tick(fwdSeq[s], "rev");
    end
    // stall past the limit (R4, R6)
    for (int h = 0; h < MAXC + 5; h++) tick(fwdSeq[0], "stall");

    // R2: Hall activity without a tick changes nothing
    begin
      int cntBefore;
      cntBefore = int'(runCnt);
      @(negedge clk);
      {hallA, hallB, hallC} = 3'(fwdSeq[3]);
      repeat (5) @(negedge clk);
      check("R2 runCnt without tick", int'(runCnt), cntBefore);
      check("R2 sector without tick", int'(sector), (mPrevSec > 5) ? 5 : mPrevSec);
      {hallA, hallB, hallC} = 3'(mPrevCode);
      tick(mPrevCode, "R2 same code");
    end

    // smoothed speed (R7) with k=30, both directions
    @(negedge clk);
    filtPct = PCT_W'(30);
    for (int s = 0; s < 24; s++) begin
      tick(fwdSeq[s % 6], "filt");
      tick(fwdSeq[s % 6], "filt");
    end
    for (int s = 0; s < 12; s++) begin
      tick(fwdSeq[5 - (s % 6)], "filtrev");
      tick(fwdSeq[5 - (s % 6)], "filtrev");
    end

    // exhaustive ordered code pairs including invalid 0 and 7 (R1, R3)
    @(negedge clk);
    filtPct = PCT_W'(60);
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        tick(a, "pair");
        tick(b, "pair");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule